// File: doc/BRIEF.md
# Carry-Chained Add/Subtract/Rotate Unit

This block is a small N-bit arithmetic stage with a persistent carry bit. Each accepted operation takes two operands and a 3-bit operation code. It returns one registered result with a carry/borrow bit, a negative bit, a zero bit and an overflow bit. It also returns two compare outputs, signed and unsigned less-than, which are only meaningful after a subtraction.

The carry bit is held in a register between operations. Add-with-carry, subtract-with-borrow and the two single-bit rotates read the value that the previous accepted operation left behind. Software can therefore build wide sums, differences and shifts one word per operation.

Operations enter on a valid/ready handshake and leave on a second one, with one cycle of latency.
- The block asserts `in_ready` when its single output slot is empty or is being drained in the same cycle.
- An offered operation that is not accepted changes nothing. This includes the carry register.
- While `out_valid` is high and `out_ready` is low, every output holds steady.

Top module: `carry_alu`

## Requirements
- R1: Code 0 (add) returns the low N bits of A+B, and C is bit N of the full sum.
- R2: Code 1 (add with carry) returns the low N bits of A+B+Cprev, and C is bit N of that sum. Cprev is the carry left by the previous accepted operation.
- R3: Code 2 (subtract) returns A-B modulo 2^N. C is a borrow: it is 1 exactly when B is greater than A, both taken as unsigned.
- R4: Code 3 (subtract with borrow) returns A-B-Cprev modulo 2^N. C is 1 exactly when B+Cprev exceeds A, unsigned.
- R5: Code 4 (rotate right through carry) returns Cprev in the top bit and A[N-1:1] below it. The new C is A[0].
- R6: Code 5 (rotate left through carry) returns A[N-2:0] above Cprev in bit 0. The new C is A[N-1].
- R7: V is set on codes 0 and 1 when the operand signs agree and the result sign differs from them. V is set on codes 2 and 3 when the operand signs differ and the result sign differs from A's. V is 0 for codes 4 to 7, and a subtraction of operands with the same sign never sets V.
- R8: N equals the result's top bit, and Z is 1 exactly when the result is all zeros.
- R9: The signed less-than output is N XOR V, and the unsigned less-than output is C. After code 2 they equal A<B, signed and unsigned respectively.
- R10: Codes 6 and 7 return A unchanged and leave the carry register as it was.
- R11: The carry register is cleared by reset. It changes only when an operation is accepted (`in_valid` and `in_ready` both high).
- R12: `in_ready` equals NOT `out_valid` OR `out_ready`. The result of an operation accepted on one clock edge appears on the outputs after that edge. While `out_valid` is high and `out_ready` is low, `out_valid` and every result output hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 3 | Operation code (see R1 to R10) |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | Result slot holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | WIDTH | Result word |
| out_c | output | 1 | Carry or borrow after the operation |
| out_n | output | 1 | Result negative |
| out_z | output | 1 | Result zero |
| out_v | output | 1 | Signed overflow |
| out_lt_s | output | 1 | Signed less-than (N XOR V) |
| out_lt_u | output | 1 | Unsigned less-than (C) |

## Verification
Two functions can meet in one cycle.
- Draining a held result while taking a new operation. The bench stalls the output with a carry-reading operation offered, then releases `out_ready`. The accepted result must show that the stall left the carry untouched.
- Consuming a carry in the cycle right after it was written. Operations are kept valid on consecutive edges, so an add is followed at once by a rotate or a carry-in add. The second result must take the first one's carry.

Every operation is also swept over all operand pairs and both prior carry values at a 4-bit width. Each result is checked against arithmetic on integers.

// File: rtl/calu_pkg.sv
package calu_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADC   = 3'd1,
    OP_SUB   = 3'd2,
    OP_SBB   = 3'd3,
    OP_RRC   = 3'd4,
    OP_RLC   = 3'd5,
    OP_PASS6 = 3'd6,
    OP_PASS7 = 3'd7
  } calu_op_e;

  typedef struct packed {
    logic c;
    logic n;
    logic z;
    logic v;
  } calu_flags_t;

endpackage

// File: rtl/calu_addsub.sv
module calu_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             do_sub,
  input  logic             use_carry,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic             cin_raw;
  logic             cin_eff;
  logic [WIDTH:0]   total;

  always_comb begin
    // Subtraction adds the inverted operand plus one, less any borrow in.
    b_eff     = do_sub ? ~b : b;
    cin_raw   = use_carry & carry_in;
    cin_eff   = do_sub ? ~cin_raw : cin_raw;
    total     = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_eff};
    sum       = total[MSB:0];
    // The flag is a borrow on subtraction: the raw carry inverted.
    carry_out = do_sub ? ~total[WIDTH] : total[WIDTH];
    ovf       = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/calu_rotate.sv
module calu_rotate #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic             carry_in,
  input  logic             to_left,
  output logic [WIDTH-1:0] res,
  output logic             carry_out
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] right_res;
  logic [WIDTH-1:0] left_res;

  assign right_res[MSB] = carry_in;
  assign left_res[0]    = carry_in;

  genvar i;
  generate
    for (i = 0; i < MSB; i++) begin : g_bits
      assign right_res[i]  = a[i+1];
      assign left_res[i+1] = a[i];
    end
  endgenerate

  always_comb begin
    res       = to_left ? left_res : right_res;
    carry_out = to_left ? a[MSB] : a[0];
  end
endmodule

// File: rtl/calu_flag_gen.sv
module calu_flag_gen
  import calu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] res,
  input  logic             carry,
  input  logic             ovf,
  output calu_flags_t      flags,
  output logic             lt_signed,
  output logic             lt_unsigned
);
  always_comb begin
    flags.c     = carry;
    flags.n     = res[WIDTH-1];
    flags.z     = ~|res;
    flags.v     = ovf;
    lt_signed   = flags.n ^ flags.v;
    lt_unsigned = flags.c;
  end
endmodule

// File: rtl/carry_alu.sv
module carry_alu
  import calu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_res,
  output logic             out_c,
  output logic             out_n,
  output logic             out_z,
  output logic             out_v,
  output logic             out_lt_s,
  output logic             out_lt_u
);
  calu_op_e         op;
  logic             accept;
  logic             carry_q;

  logic [WIDTH-1:0] as_sum;
  logic             as_carry;
  logic             as_ovf;
  logic [WIDTH-1:0] rot_res;
  logic             rot_carry;

  logic [WIDTH-1:0] res_d;
  logic             c_d;
  logic             v_d;
  calu_flags_t      flags_d;
  logic             lts_d;
  logic             ltu_d;

  logic             is_sub;
  logic             with_carry;

  assign op     = calu_op_e'(in_op);
  assign accept = in_valid & in_ready;

  always_comb begin
    is_sub     = (op == OP_SUB) || (op == OP_SBB);
    with_carry = (op == OP_ADC) || (op == OP_SBB);
  end

  calu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a         (in_a),
    .b         (in_b),
    .do_sub    (is_sub),
    .use_carry (with_carry),
    .carry_in  (carry_q),
    .sum       (as_sum),
    .carry_out (as_carry),
    .ovf       (as_ovf)
  );

  calu_rotate #(.WIDTH(WIDTH)) u_rotate (
    .a         (in_a),
    .carry_in  (carry_q),
    .to_left   (op == OP_RLC),
    .res       (rot_res),
    .carry_out (rot_carry)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res_d = as_sum;
        c_d   = as_carry;
        v_d   = as_ovf;
      end
      OP_RRC, OP_RLC: begin
        res_d = rot_res;
        c_d   = rot_carry;
        v_d   = 1'b0;
      end
      default: begin
        res_d = in_a;
        c_d   = carry_q;
        v_d   = 1'b0;
      end
    endcase
  end

  calu_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .res         (res_d),
    .carry       (c_d),
    .ovf         (v_d),
    .flags       (flags_d),
    .lt_signed   (lts_d),
    .lt_unsigned (ltu_d)
  );

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q   <= 1'b0;
      out_valid <= 1'b0;
      out_res   <= '0;
      out_c     <= 1'b0;
      out_n     <= 1'b0;
      out_z     <= 1'b0;
      out_v     <= 1'b0;
      out_lt_s  <= 1'b0;
      out_lt_u  <= 1'b0;
    end else if (accept) begin
      carry_q   <= c_d;
      out_valid <= 1'b1;
      out_res   <= res_d;
      out_c     <= flags_d.c;
      out_n     <= flags_d.n;
      out_z     <= flags_d.z;
      out_v     <= flags_d.v;
      out_lt_s  <= lts_d;
      out_lt_u  <= ltu_d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/carry_alu_chk.sv
module carry_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic [WIDTH-1:0] in_a,
  input logic [WIDTH-1:0] in_b,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_res,
  input logic             out_c,
  input logic             out_v,
  input logic             out_lt_u,
  input logic             carry_q
);
  logic acc;
  assign acc = in_valid & in_ready;

  // R1
  add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 3'd0) |=>
      {out_c, out_res} == ({1'b0, $past(in_a)} + {1'b0, $past(in_b)}));

  // R5
  rrc_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 3'd4) |=>
      (out_res[WIDTH-1] == $past(carry_q)) && (carry_q == $past(in_a[0])));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 3'd2 && in_a[WIDTH-1] == in_b[WIDTH-1]) |=> !out_v);

  // R9
  unsigned_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 3'd2) |=> out_lt_u == ($past(in_a) < $past(in_b)));

  // R11
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(carry_q));

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_res) && $stable(out_c));

  // R12
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind carry_alu carry_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .in_a      (in_a),
  .in_b      (in_b),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_res   (out_res),
  .out_c     (out_c),
  .out_v     (out_v),
  .out_lt_u  (out_lt_u),
  .carry_q   (carry_q)
);

// File: tb/tb_carry_alu.sv
module tb_carry_alu;
  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [2:0]   in_op;
  logic [W-1:0] in_a;
  logic [W-1:0] in_b;
  logic         out_valid;
  logic         out_ready;
  logic [W-1:0] out_res;
  logic         out_c, out_n, out_z, out_v, out_lt_s, out_lt_u;

  int errors = 0;
  int checks = 0;
  int c_m = 0;

  always #5 clk = ~clk;

  carry_alu #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .out_c(out_c), .out_n(out_n),
    .out_z(out_z), .out_v(out_v), .out_lt_s(out_lt_s), .out_lt_u(out_lt_u)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sgn(input int x);
    return (x >= HALF) ? x - (1 << W) : x;
  endfunction

  task automatic model(input int op, input int a, input int b, input int cin,
                       output int r, output int c, output int v);
    int t;
    int st;
    v = 0;
    case (op)
      0: begin t = a + b; r = t & MASK; c = t >> W; st = sgn(a) + sgn(b); end
      1: begin t = a + b + cin; r = t & MASK; c = t >> W; st = sgn(a) + sgn(b) + cin; end
      2: begin r = (a - b) & MASK; c = (b > a); st = sgn(a) - sgn(b); end
      3: begin r = (a - b - cin) & MASK; c = ((b + cin) > a); st = sgn(a) - sgn(b) - cin; end
      4: begin r = (cin << (W - 1)) | (a >> 1); c = a & 1; st = 0; end
      5: begin r = ((a << 1) & MASK) | cin; c = (a >> (W - 1)) & 1; st = 0; end
      default: begin r = a; c = cin; st = 0; end
    endcase
    if (op <= 3) v = (st > HALF - 1 || st < -HALF) ? 1 : 0;
  endtask

  // Checks the outputs of an operation accepted on the previous edge
  task automatic check_out(input int op, input int a, input int b, input int cin, input string tag);
    int r, c, v;
    string rq;
    model(op, a, b, cin, r, c, v);
    case (op)
      0: rq = "R1"; 1: rq = "R2"; 2: rq = "R3"; 3: rq = "R4";
      4: rq = "R5"; 5: rq = "R6"; default: rq = "R10";
    endcase
    chk(out_valid == 1'b1, {"R12 valid ", tag}, out_valid, 1);
    chk(out_res == r[W-1:0], {rq, " result ", tag}, out_res, r);
    chk(out_c == c[0], {rq, " carry ", tag}, out_c, c);
    chk(out_v == v[0], {"R7 overflow ", tag}, out_v, v);
    chk(out_n == r[W-1], {"R8 negative ", tag}, out_n, r[W-1]);
    chk(out_z == (r == 0), {"R8 zero ", tag}, out_z, (r == 0));
    chk(out_lt_s == (r[W-1] ^ v[0]), {"R9 signed lt ", tag}, out_lt_s, r[W-1] ^ v[0]);
    chk(out_lt_u == c[0], {"R9 unsigned lt ", tag}, out_lt_u, c);
    if (op == 2) begin
      chk(out_lt_s == (sgn(a) < sgn(b)), {"R9 signed compare ", tag}, out_lt_s, sgn(a) < sgn(b));
      chk(out_lt_u == (a < b), {"R9 unsigned compare ", tag}, out_lt_u, a < b);
    end
    c_m = c;
  endtask

  task automatic run_op(input int op, input int a, input int b, input string tag);
    int cin;
    cin = c_m;
    @(negedge clk);
    in_op = op[2:0]; in_a = a[W-1:0]; in_b = b[W-1:0]; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(op, a, b, cin, tag);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", checks, -1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_op = '0; in_a = '0; in_b = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R11 / R12: reset state
    chk(out_valid == 1'b0, "R12 reset out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R12 reset in_ready", in_ready, 1);
    // R11: reset carry is 0, visible through rotate right of zero
    c_m = 0;
    run_op(4, 0, 0, "reset carry");

    // Exhaustive sweep: every op, both prior carries, all operand pairs
    for (int op = 0; op < 8; op++)
      for (int cin = 0; cin < 2; cin++)
        for (int a = 0; a <= MASK; a++)
          for (int b = 0; b <= MASK; b++) begin
            run_op(0, MASK, cin, "carry preset");
            run_op(op, a, b, "sweep");
          end

    // Same-cycle case 1: stalled offer leaves carry alone (R11), output holds (R12)
    run_op(0, MASK, 1, "stall preset");
    out_ready = 1'b0;
    in_op = 3'd1; in_a = '0; in_b = '0; in_valid = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R12 in_ready low when stalled", in_ready, 0);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1 && out_res == 0 && out_c == 1'b1, "R12 held result", out_res, 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(1, 0, 0, 1, "R11 drain+accept");

    // Same-cycle case 2: back-to-back, second op reads carry just written
    @(negedge clk);
    in_op = 3'd0; in_a = MASK[W-1:0]; in_b = 1; in_valid = 1'b1;
    @(negedge clk);
    check_out(0, MASK, 1, c_m, "b2b first");
    in_op = 3'd4; in_a = '0; in_b = '0;
    @(negedge clk);
    check_out(4, 0, 0, 1, "b2b rotate");
    in_op = 3'd1; in_a = 5; in_b = 2;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(1, 5, 2, 0, "b2b adc");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule